// File: doc/BRIEF.md
# Serial Keyboard Command Responder

This block models the keyboard endpoint that sits behind one channel of a serial controller. The host writes command bytes to the channel; when the transmitter is enabled and the keyboard is not disabled, each byte is interpreted and may produce a fixed reply. Replies, and the key codes made from key events, go into a byte queue. The host empties the queue one byte at a time through data-port reads.

A key event is a 7-bit key code, a release flag and a lock selector. The caps-lock and num-lock keys each pass through a toggle filter. This filter lets only every other press and every other release through, so a locking key reports one press and one release per full lock/unlock cycle. The queue-not-empty output drives the channel's receive-available status.

Top module: `kbd_responder`

## Requirements
- R1: After reset the queue is empty, `rx_avail` is 0, `rd_data` reads 0, both lock filters are in their initial state and no LED byte is pending.
- R2: An accepted command 0x01 empties the queue and then enqueues 0xFF, 0x04 and 0x7F, in that order.
- R3: An accepted command 0x0E makes the next accepted command byte be discarded without effect, whatever its value.
- R4: An accepted command 0x07 or 0x0F empties the queue and then enqueues 0xFE followed by 0x21.
- R5: Any other accepted command byte leaves the queue unchanged.
- R6: A command byte is accepted only when `tx_enable` is 1 and `kbd_disable` is 0. A byte that is not accepted has no effect, and it does not use up a pending LED discard.
- R7: A key event with `lock_sel` = 0 enqueues one byte, `{key_release, key_code}`. Bit 7 is 1 for a release and 0 for a press.
- R8: `lock_sel` = 1 selects the caps filter and 2 selects the num filter. Each filter keeps its own 2-bit state. A press toggles bit 0 and is dropped if the result is 2. A release toggles bit 1 and is dropped if the result is 3. Starting from reset, a press/release/press/release sequence therefore yields only the first press and the second release.
- R9: The queue holds 256 bytes. A byte offered while the queue is full is dropped, and the stored bytes are kept.
- R10: `rd_data` shows the oldest byte, or 0 when the queue is empty. A pulse on `rd_en` removes that byte at the clock edge. Reading an empty queue returns 0 and changes nothing.
- R11: `rx_avail` is 1 exactly when the queue holds at least one byte.
- R12: If a command and a key event arrive in the same cycle, the command's flush and reply bytes are applied first and the key byte is enqueued after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A host command byte is presented this cycle |
| cmd_byte | input | 8 | Host command byte |
| tx_enable | input | 1 | Channel transmitter enable |
| kbd_disable | input | 1 | Keyboard disabled; commands are ignored |
| key_valid | input | 1 | A key event is presented this cycle |
| key_code | input | 7 | Key code of the event |
| key_release | input | 1 | 1 for a release, 0 for a press |
| lock_sel | input | 2 | 0 normal key, 1 caps lock, 2 num lock |
| rd_en | input | 1 | Data-port read; removes the head byte |
| rd_data | output | 8 | Head byte of the queue, 0 when empty |
| rx_avail | output | 1 | Queue not empty |

## Verification
Commands are sent with the queue already holding key bytes. This shows the difference between replies that flush the queue and codes that must leave it untouched. LED discards are followed first by a command that would otherwise reply, and then by the same command blocked by the enable gates, which shows whether a blocked byte wrongly uses up the discard. Caps and num events are interleaved, so a shared filter state or a wrong drop rule changes the emitted byte order. A same-cycle command and key event checks the merge order. An overfill of 300 key bytes, each byte equal to its index, shows exactly which writes were kept and which were dropped.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int BYTE_W    = 8;
    localparam int CMD_SLOTS = 3;
    localparam int PUSH_SLOTS = CMD_SLOTS + 1;

    typedef enum logic [1:0] {
        LOCK_NONE = 2'd0,
        LOCK_CAPS = 2'd1,
        LOCK_NUM  = 2'd2
    } lock_sel_e;

    localparam logic [7:0] OP_RESET    = 8'h01;
    localparam logic [7:0] OP_LEDS     = 8'h0E;
    localparam logic [7:0] OP_LAYOUT_A = 8'h07;
    localparam logic [7:0] OP_LAYOUT_B = 8'h0F;

    typedef struct packed {
        logic                                flush;
        logic [1:0]                          cnt;
        logic [CMD_SLOTS-1:0][BYTE_W-1:0]    bytes;
    } reply_t;
endpackage

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter
    import kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_valid,
    input  logic       key_release,
    input  logic [1:0] lock_sel,
    output logic       emit
);
    typedef struct packed {
        logic [1:0] caps;
        logic [1:0] num;
    } lock_st_t;

    lock_st_t st_d, st_q;
    lock_sel_e sel;
    logic [1:0] flip, nxt;

    always_comb begin
        sel  = lock_sel_e'(lock_sel);
        st_d = st_q;
        emit = key_valid;
        flip = key_release ? 2'b10 : 2'b01;
        nxt  = 2'b00;
        if (key_valid && sel == LOCK_CAPS) begin
            nxt       = st_q.caps ^ flip;
            st_d.caps = nxt;
            emit      = key_release ? (nxt != 2'd3) : (nxt != 2'd2);
        end else if (key_valid && sel == LOCK_NUM) begin
            nxt      = st_q.num ^ flip;
            st_d.num = nxt;
            emit     = key_release ? (nxt != 2'd3) : (nxt != 2'd2);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CAPS_FIRST_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && lock_sel == 2'd1 && !key_release && st_q.caps == 2'd0 |-> emit); // R8
    AST_CAPS_FIRST_RELEASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && lock_sel == 2'd1 && key_release && st_q.caps == 2'd1 |-> !emit); // R8
    AST_NUM_SECOND_PRESS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && lock_sel == 2'd2 && !key_release && st_q.num == 2'd3 |-> !emit); // R8
endmodule

// File: rtl/kbd_cmd_decoder.sv
module kbd_cmd_decoder
    import kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       tx_enable,
    input  logic       kbd_disable,
    output reply_t     reply
);
    typedef struct packed {
        logic led_arm;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic accept;

    always_comb begin
        accept = cmd_valid && tx_enable && !kbd_disable;
        st_d   = st_q;
        reply  = '0;
        if (accept) begin
            if (st_q.led_arm) begin
                st_d.led_arm = 1'b0;
            end else begin
                unique case (cmd_byte)
                    OP_RESET: begin
                        reply.flush    = 1'b1;
                        reply.cnt      = 2'd3;
                        reply.bytes[0] = 8'hFF;
                        reply.bytes[1] = 8'h04;
                        reply.bytes[2] = 8'h7F;
                    end
                    OP_LEDS: st_d.led_arm = 1'b1;
                    OP_LAYOUT_A, OP_LAYOUT_B: begin
                        reply.flush    = 1'b1;
                        reply.cnt      = 2'd2;
                        reply.bytes[0] = 8'hFE;
                        reply.bytes[1] = 8'h21;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LED_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && tx_enable && !kbd_disable && st_q.led_arm |-> reply.cnt == 2'd0 && !reply.flush); // R3
    AST_LED_DISCARD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && tx_enable && !kbd_disable && st_q.led_arm |=> !st_q.led_arm); // R3
    AST_GATED_KEEPS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_enable && !kbd_disable) |=> st_q.led_arm == $past(st_q.led_arm)); // R6
endmodule

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue #(
    parameter int DEPTH = 256,
    parameter int SLOTS = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1,
    localparam int PW = $clog2(SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [PW-1:0]         push_cnt,
    input  logic [SLOTS-1:0][7:0] push_bytes,
    input  logic                  pop,
    output logic [7:0]            rd_data,
    output logic                  not_empty
);
    typedef struct packed {
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } q_st_t;

    q_st_t st_d, st_q;
    logic [7:0] mem [DEPTH];
    logic                      pop_ok;
    logic [CW-1:0]             base_cnt;
    logic [AW-1:0]             base_r;
    logic [PW-1:0]             acc;
    logic [SLOTS-1:0]          slot_wr;
    logic [SLOTS-1:0][AW-1:0]  slot_idx;

    always_comb begin
        pop_ok   = pop && (st_q.count != '0) && !flush;
        base_cnt = flush ? '0 : st_q.count - CW'(pop_ok);
        base_r   = st_q.rptr + AW'(pop_ok);
        acc      = '0;
        for (int i = 0; i < SLOTS; i++) begin
            slot_wr[i]  = (PW'(i) < push_cnt) &&
                          (({1'b0, base_cnt} + (CW+1)'(i)) < (CW+1)'(DEPTH));
            slot_idx[i] = base_r + base_cnt[AW-1:0] + AW'(i);
            if (slot_wr[i]) acc = acc + 1'b1;
        end
        st_d.rptr  = base_r;
        st_d.count = base_cnt + CW'(acc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (slot_wr[i]) mem[slot_idx[i]] <= push_bytes[i];
        end
    end

    assign not_empty = (st_q.count != '0);
    assign rd_data   = not_empty ? mem[st_q.rptr] : 8'h00;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH)); // R9
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count == CW'(DEPTH) && !pop && !flush |=> st_q.count == CW'(DEPTH)); // R9
    AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count == '0 && pop && push_cnt == '0 |=> st_q.count == '0 && $stable(st_q.rptr)); // R10
endmodule

// File: rtl/kbd_responder.sv
module kbd_responder
    import kbd_pkg::*;
#(
    parameter int QUEUE_DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       tx_enable,
    input  logic       kbd_disable,
    input  logic       key_valid,
    input  logic [6:0] key_code,
    input  logic       key_release,
    input  logic [1:0] lock_sel,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rx_avail
);
    localparam int PW = $clog2(PUSH_SLOTS + 1);

    reply_t                    reply;
    logic                      key_emit;
    logic [7:0]                key_byte;
    logic [PW-1:0]             push_cnt;
    logic [PUSH_SLOTS-1:0][7:0] push_bytes;

    kbd_cmd_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .tx_enable(tx_enable), .kbd_disable(kbd_disable), .reply(reply)
    );

    kbd_lock_filter u_lock (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_release(key_release),
        .lock_sel(lock_sel), .emit(key_emit)
    );

    always_comb begin
        key_byte = {key_release, key_code};
        for (int i = 0; i < PUSH_SLOTS; i++) begin
            push_bytes[i] = key_byte;
            if (i < CMD_SLOTS && 2'(i) < reply.cnt) push_bytes[i] = reply.bytes[i];
        end
        push_cnt = PW'(reply.cnt) + PW'(key_emit);
    end

    kbd_byte_queue #(.DEPTH(QUEUE_DEPTH), .SLOTS(PUSH_SLOTS)) u_q (
        .clk(clk), .rst_n(rst_n), .flush(reply.flush), .push_cnt(push_cnt),
        .push_bytes(push_bytes), .pop(rd_en), .rd_data(rd_data), .not_empty(rx_avail)
    );

    AST_BLOCKED_CMD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !(tx_enable && !kbd_disable) && !key_valid && !rd_en |=> $stable(rx_avail) && $stable(rd_data)); // R6
    AST_AVAIL_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_avail && !cmd_valid && !key_valid |=> !rx_avail); // R11
endmodule

// File: tb/tb_kbd_responder.sv
module tb_kbd_responder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, tx_enable = 1'b0, kbd_disable = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic key_valid = 1'b0, key_release = 1'b0;
    logic [6:0] key_code = 7'h00;
    logic [1:0] lock_sel = 2'd0;
    logic rd_en = 1'b0;
    logic [7:0] rd_data;
    logic rx_avail;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    kbd_responder dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .tx_enable(tx_enable), .kbd_disable(kbd_disable), .key_valid(key_valid),
        .key_code(key_code), .key_release(key_release), .lock_sel(lock_sel),
        .rd_en(rd_en), .rd_data(rd_data), .rx_avail(rx_avail)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_cmd(logic [7:0] b);
        cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_key(logic [6:0] c, logic rel, logic [1:0] sel);
        key_valid = 1'b1; key_code = c; key_release = rel; lock_sel = sel;
        @(negedge clk);
        key_valid = 1'b0; lock_sel = 2'd0;
    endtask

    task automatic pop_exp(string req, logic [7:0] exp);
        chk(req, {7'b0, rx_avail}, 8'h01);
        chk(req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic exp_empty(string req);
        chk(req, {7'b0, rx_avail}, 8'h00);
        chk(req, rd_data, 8'h00);
    endtask

    task automatic t_reset_state();
        do_reset();
        exp_empty("R1 reset");
    endtask

    task automatic t_reset_cmd();
        tx_enable = 1'b1;
        send_key(7'h11, 1'b0, 2'd0);
        send_cmd(8'h01);
        pop_exp("R2 byte0", 8'hFF);
        pop_exp("R2 byte1", 8'h04);
        pop_exp("R2 byte2", 8'h7F);
        exp_empty("R11 drained");
    endtask

    task automatic t_layout();
        send_key(7'h10, 1'b0, 2'd0);
        send_key(7'h12, 1'b1, 2'd0);
        send_cmd(8'h07);
        pop_exp("R4 07 b0", 8'hFE);
        pop_exp("R4 07 b1", 8'h21);
        exp_empty("R4 07 end");
        send_key(7'h13, 1'b0, 2'd0);
        send_cmd(8'h0F);
        pop_exp("R4 0F b0", 8'hFE);
        pop_exp("R4 0F b1", 8'h21);
        exp_empty("R4 0F end");
    endtask

    task automatic t_ignored();
        send_key(7'h22, 1'b0, 2'd0);
        send_cmd(8'h55);
        send_cmd(8'h00);
        send_cmd(8'hFF);
        pop_exp("R5 kept", 8'h22);
        exp_empty("R5 end");
    endtask

    task automatic t_led();
        send_cmd(8'h0E);
        send_cmd(8'h01);
        exp_empty("R3 discarded");
        send_cmd(8'h01);
        pop_exp("R3 after", 8'hFF);
        pop_exp("R3 after", 8'h04);
        pop_exp("R3 after", 8'h7F);
    endtask

    task automatic t_gate();
        tx_enable = 1'b0;
        send_cmd(8'h01);
        exp_empty("R6 tx off");
        tx_enable = 1'b1; kbd_disable = 1'b1;
        send_cmd(8'h07);
        exp_empty("R6 disabled");
        kbd_disable = 1'b0;
        send_cmd(8'h0E);
        tx_enable = 1'b0;
        send_cmd(8'h07);
        tx_enable = 1'b1;
        send_cmd(8'h07);
        exp_empty("R6 arm kept");
        send_cmd(8'h07);
        pop_exp("R6 next", 8'hFE);
        pop_exp("R6 next", 8'h21);
    endtask

    task automatic t_keys();
        send_key(7'h45, 1'b0, 2'd0);
        send_key(7'h45, 1'b1, 2'd0);
        pop_exp("R7 press", 8'h45);
        pop_exp("R7 release", 8'hC5);
    endtask

    task automatic t_lock();
        send_key(7'h77, 1'b0, 2'd1);
        send_key(7'h62, 1'b0, 2'd2);
        send_key(7'h77, 1'b1, 2'd1);
        send_key(7'h62, 1'b1, 2'd2);
        send_key(7'h77, 1'b0, 2'd1);
        send_key(7'h62, 1'b0, 2'd2);
        send_key(7'h77, 1'b1, 2'd1);
        send_key(7'h62, 1'b1, 2'd2);
        pop_exp("R8 caps press", 8'h77);
        pop_exp("R8 num press", 8'h62);
        pop_exp("R8 caps release", 8'hF7);
        pop_exp("R8 num release", 8'hE2);
        exp_empty("R8 end");
        send_key(7'h77, 1'b0, 2'd1);
        do_reset();
        tx_enable = 1'b1;
        exp_empty("R1 flushed");
        send_key(7'h77, 1'b0, 2'd1);
        pop_exp("R1 lock cleared", 8'h77);
    endtask

    task automatic t_empty_read();
        exp_empty("R10 pre");
        pop_empty();
        exp_empty("R10 post");
        send_key(7'h2A, 1'b0, 2'd0);
        pop_exp("R10 intact", 8'h2A);
    endtask

    task automatic pop_empty();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_same_cycle();
        cmd_valid = 1'b1; cmd_byte = 8'h01;
        key_valid = 1'b1; key_code = 7'h33; key_release = 1'b0; lock_sel = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0; key_valid = 1'b0;
        pop_exp("R12 b0", 8'hFF);
        pop_exp("R12 b1", 8'h04);
        pop_exp("R12 b2", 8'h7F);
        pop_exp("R12 key", 8'h33);
        exp_empty("R12 end");
    endtask

    task automatic t_full();
        for (int k = 0; k < 300; k++) send_key(7'(k), k[7], 2'd0);
        for (int k = 0; k < 256; k++) begin
            if (rd_data !== 8'(k) || rx_avail !== 1'b1) pop_exp("R9 fill", 8'(k));
            else begin
                n_chk++;
                pop_empty();
            end
        end
        exp_empty("R9 overflow dropped");
    endtask

    initial begin
        t_reset_state();
        t_reset_cmd();
        t_layout();
        t_ignored();
        t_led();
        t_gate();
        t_keys();
        t_lock();
        t_empty_read();
        t_same_cycle();
        t_full();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule